// File: doc/BRIEF.md
# Byte FIFO Pair with Threshold Interrupts

This block wraps a pair of byte-wide synchronous FIFOs, one feeding an external serial shift engine (transmit) and one collecting what the engine receives. Both FIFOs have the same depth, set by a parameter (64 or 128 entries). A small word-addressed register bus gives software the transmit data port, the receive data port, a FIFO control word, a fill-count status word, an interrupt enable word and a write-one-to-clear interrupt status word.

Each FIFO has its own 8-bit trigger level. The receive side raises a ready flag once enough bytes have arrived, and the transmit side raises a request flag once it has drained far enough. The same threshold conditions, gated by per-FIFO enables, drive two DMA request lines. A receive byte that arrives while the receive FIFO is full is dropped and recorded as an overflow. A single-cycle pulse from the shift engine records transfer completion. The single interrupt output combines all pending flags with their enables.

Register word addresses: 0 interrupt enable, 1 interrupt status, 2 FIFO control, 3 FIFO status, 4 transmit data (write pushes), 5 receive data (read with `reg_re` pops). Reads are combinational on `reg_addr`; writes take effect at the clock edge where `reg_we` is high.

Top module: `fifo_irq_unit`

## Requirements
- R1: After reset the enable word, trigger levels, DMA enables and both fill counts are zero, and `irq`, `dma_tx_req` and `dma_rx_req` are low.
- R2: FIFO control word: bits 7:0 RX trigger, bit 8 RX DMA enable, bit 15 RX flush, bits 23:16 TX trigger, bit 24 TX DMA enable, bit 31 TX flush; a flush bit empties its FIFO at that write's clock edge and reads back as 0.
- R3: The FIFO status word carries the RX fill count in bits 7:0 and the TX fill count in bits 23:16, all other bits zero.
- R4: Flag bit 0 (RX ready) is set one clock after the RX count is nonzero and at least the RX trigger.
- R5: Flag bit 4 (TX request) is set one clock after the TX count is at or below the TX trigger.
- R6: Writing 1 to a status bit clears it at that edge and 0 leaves it; a level flag (bits 0, 4) whose condition still holds is set again one clock later, and otherwise stays clear.
- R7: A receive push while the RX FIFO is full is dropped without changing the count or contents and sets flag bit 8 (overflow).
- R8: An `eng_done` pulse sets flag bit 12; when that pulse falls in the same cycle as a write-one-to-clear of bit 12, the flag stays set.
- R9: `irq` is high exactly when some status flag is set together with the enable bit at the same position of the enable word.
- R10: `dma_rx_req` follows the RX ready condition and `dma_tx_req` the TX request condition, each gated by its DMA enable, with no clock of delay after the count changes.
- R11: Bytes written to the transmit port appear on `eng_tx_byte` in write order, and bytes pushed by the engine are returned by receive-port reads in push order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (pops the receive port) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| eng_tx_pop | input | 1 | Engine takes the head transmit byte |
| eng_tx_byte | output | 8 | Head of the transmit FIFO |
| eng_tx_empty | output | 1 | Transmit FIFO is empty |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_byte | input | 8 | Received byte |
| eng_done | input | 1 | Transfer complete pulse |
| irq | output | 1 | Interrupt request |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |

## Verification
The flag register must settle two updates landing in one cycle: a software write-one-to-clear and a hardware set of the same bit. The bench drives `eng_done` high in the very cycle its status bit is written with 1 and expects the bit to survive, then clears it alone and expects it gone. For the level flags the same clash is judged the other way: the clear wins for one cycle and the bench reads the bit as 0 right after the write and as 1 one clock later while the fill condition still holds.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;

  typedef enum logic [2:0] {
    A_IEN   = 3'd0,
    A_ISTAT = 3'd1,
    A_FCTRL = 3'd2,
    A_FSTAT = 3'd3,
    A_TXD   = 3'd4,
    A_RXD   = 3'd5
  } reg_sel_e;

  localparam int NFLAG = 4;
  // flags 2 (overflow) and 3 (done) are events, 0 and 1 are levels
  localparam logic [NFLAG-1:0] FLAG_IS_EVENT = 4'b1100;

  function automatic int flag_pos(input int idx);
    return 4 * idx;
  endfunction

  function automatic logic rx_reached(input logic [7:0] cnt, input logic [7:0] trig);
    return (cnt != 8'd0) && (cnt >= trig);
  endfunction

  function automatic logic tx_drained(input logic [7:0] cnt, input logic [7:0] trig);
    return cnt <= trig;
  endfunction

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty,
  output logic                         drop
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push & ~full & ~flush;
  assign do_pop  = pop & ~empty & ~flush;
  assign drop    = push & full & ~flush;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + PTR_W'(1);
      if (do_pop)  rd_ptr <= rd_ptr + PTR_W'(1);
      case ({do_push, do_pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  // R7
  drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !pop) |=> $stable(count));

  // R2
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));

endmodule

// File: rtl/sticky_flag.sv
module sticky_flag #(
  parameter bit EVENT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  input  logic clr,
  output logic flag
);
  logic nxt;

  generate
    if (EVENT) begin : g_event
      // a hardware event outranks a software clear in the same cycle
      assign nxt = cond | (flag & ~clr);

      // R8
      event_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cond |=> flag);
    end else begin : g_level
      // the clear wins; a persisting condition re-sets one cycle later
      assign nxt = ~clr & (flag | cond);

      // R6
      level_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !flag);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= nxt;
  end

endmodule

// File: rtl/fifo_irq_unit.sv
module fifo_irq_unit
  import fifo_irq_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic        reg_re,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        eng_tx_pop,
  output logic [7:0]  eng_tx_byte,
  output logic        eng_tx_empty,
  input  logic        eng_rx_push,
  input  logic [7:0]  eng_rx_byte,
  input  logic        eng_done,
  output logic        irq,
  output logic        dma_tx_req,
  output logic        dma_rx_req
);
  localparam int CNT_W = $clog2(DEPTH+1);

  reg_sel_e sel;
  logic wr_ien, wr_istat, wr_fctrl, wr_txd, rd_rxd;
  logic rx_flush, tx_flush;
  logic [7:0] rx_trig, tx_trig;
  logic rx_dma_en, tx_dma_en;
  logic [NFLAG-1:0] ien_q, flags, flag_cond, flag_clr;
  logic [CNT_W-1:0] rx_count, tx_count;
  logic [7:0] rx_cnt8, tx_cnt8, rx_head;
  logic rx_full, rx_empty, tx_full, rx_drop, tx_drop;
  logic rx_hit, tx_hit;
  logic [31:0] ien_word, st_word;

  assign sel      = reg_sel_e'(reg_addr);
  assign wr_ien   = reg_we && (sel == A_IEN);
  assign wr_istat = reg_we && (sel == A_ISTAT);
  assign wr_fctrl = reg_we && (sel == A_FCTRL);
  assign wr_txd   = reg_we && (sel == A_TXD);
  assign rd_rxd   = reg_re && (sel == A_RXD);
  assign rx_flush = wr_fctrl & reg_wdata[15];
  assign tx_flush = wr_fctrl & reg_wdata[31];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_trig   <= '0;
      tx_trig   <= '0;
      rx_dma_en <= 1'b0;
      tx_dma_en <= 1'b0;
    end else if (wr_fctrl) begin
      rx_trig   <= reg_wdata[7:0];
      rx_dma_en <= reg_wdata[8];
      tx_trig   <= reg_wdata[23:16];
      tx_dma_en <= reg_wdata[24];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ien_q <= '0;
    else if (wr_ien) begin
      for (int i = 0; i < NFLAG; i++) ien_q[i] <= reg_wdata[flag_pos(i)];
    end
  end

  byte_fifo #(.DEPTH(DEPTH), .W(8)) i_rx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush),
    .push(eng_rx_push), .din(eng_rx_byte), .pop(rd_rxd), .dout(rx_head),
    .count(rx_count), .full(rx_full), .empty(rx_empty), .drop(rx_drop)
  );

  byte_fifo #(.DEPTH(DEPTH), .W(8)) i_tx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush),
    .push(wr_txd), .din(reg_wdata[7:0]), .pop(eng_tx_pop), .dout(eng_tx_byte),
    .count(tx_count), .full(tx_full), .empty(eng_tx_empty), .drop(tx_drop)
  );

  assign rx_cnt8 = 8'(rx_count);
  assign tx_cnt8 = 8'(tx_count);
  assign rx_hit  = rx_reached(rx_cnt8, rx_trig);
  assign tx_hit  = tx_drained(tx_cnt8, tx_trig);

  assign flag_cond = {eng_done, rx_drop, tx_hit, rx_hit};

  generate
    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
      assign flag_clr[g] = wr_istat & reg_wdata[flag_pos(g)];
      sticky_flag #(.EVENT(FLAG_IS_EVENT[g])) i_flag (
        .clk(clk), .rst_n(rst_n), .cond(flag_cond[g]),
        .clr(flag_clr[g]), .flag(flags[g])
      );
    end
  endgenerate

  always_comb begin
    ien_word = '0;
    st_word  = '0;
    for (int i = 0; i < NFLAG; i++) begin
      ien_word[flag_pos(i)] = ien_q[i];
      st_word[flag_pos(i)]  = flags[i];
    end
  end

  always_comb begin
    case (sel)
      A_IEN:   reg_rdata = ien_word;
      A_ISTAT: reg_rdata = st_word;
      A_FCTRL: reg_rdata = {1'b0, 6'b0, tx_dma_en, tx_trig, 1'b0, 6'b0, rx_dma_en, rx_trig};
      A_FSTAT: reg_rdata = {8'b0, tx_cnt8, 8'b0, rx_cnt8};
      A_RXD:   reg_rdata = {24'b0, rx_head};
      default: reg_rdata = '0;
    endcase
  end

  assign irq        = |(flags & ien_q);
  assign dma_rx_req = rx_dma_en & rx_hit;
  assign dma_tx_req = tx_dma_en & tx_hit;

  // R9
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq);

  // R10
  rx_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rx_req |-> !rx_empty);

  // R4
  rx_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_hit && !flag_clr[0]) |=> flags[0]);

  // R7
  ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_rx_push && rx_full && !rx_flush) |=> flags[2]);

endmodule

// File: tb/test_fifo_irq_unit.sv
module test_fifo_irq_unit;
  import fifo_irq_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0, reg_re = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic eng_tx_pop = 1'b0;
  logic [7:0] eng_tx_byte;
  logic eng_tx_empty;
  logic eng_rx_push = 1'b0;
  logic [7:0] eng_rx_byte = '0;
  logic eng_done = 1'b0;
  logic irq, dma_tx_req, dma_rx_req;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_irq_unit #(.DEPTH(DEPTH)) i_fifo_irq_unit (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_tx_pop(eng_tx_pop), .eng_tx_byte(eng_tx_byte), .eng_tx_empty(eng_tx_empty),
    .eng_rx_push(eng_rx_push), .eng_rx_byte(eng_rx_byte), .eng_done(eng_done),
    .irq(irq), .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic rd_pop(output logic [7:0] b);
    reg_addr = A_RXD; reg_re = 1'b1;
    #1;
    b = reg_rdata[7:0];
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic push_rx(input logic [7:0] b);
    eng_rx_push = 1'b1; eng_rx_byte = b;
    @(negedge clk);
    eng_rx_push = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", 32'(irq), 0);
    check("R1 dma", {30'b0, dma_tx_req, dma_rx_req}, 0);
    rd(A_IEN, d);   check("R1 ien", d, 0);
    rd(A_FCTRL, d); check("R1 fctrl", d, 0);
    rd(A_FSTAT, d); check("R1 R3 fstat", d, 0);
    idle(2);
    rd(A_ISTAT, d); check("R5 txreq at empty", d, 32'h10);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(A_ISTAT, 32'h10);
    rd(A_ISTAT, d); check("R6 cleared", d, 0);
    idle(1);
    rd(A_ISTAT, d); check("R6 re-set", d, 32'h10);
    wr(A_ISTAT, 32'h1);
    rd(A_ISTAT, d); check("R6 zero bit no effect", d, 32'h10);
  endtask

  task automatic t_rx_thresh();
    logic [31:0] d;
    wr(A_FCTRL, 32'h0000_0104);
    wr(A_IEN, 32'h1);
    wr(A_ISTAT, 32'hFFFF_FFFF);
    for (int i = 1; i <= 3; i++) push_rx(8'hA0 + 8'(i));
    idle(1);
    rd(A_ISTAT, d); check("R4 below trigger", d & 32'h1, 0);
    check("R9 irq masked off", 32'(irq), 0);
    check("R10 rx dma low", 32'(dma_rx_req), 0);
    rd(A_FSTAT, d); check("R3 rx count", d, 32'd3);
    push_rx(8'hA4);
    check("R10 rx dma immediate", 32'(dma_rx_req), 1);
    idle(1);
    rd(A_ISTAT, d); check("R4 at trigger", d & 32'h1, 1);
    check("R9 irq", 32'(irq), 1);
  endtask

  task automatic t_rx_order();
    logic [31:0] d;
    logic [7:0] b;
    for (int i = 1; i <= 4; i++) begin
      rd_pop(b);
      check("R11 rx order", 32'(b), 32'(8'hA0 + 8'(i)));
    end
    rd(A_FSTAT, d); check("R3 rx drained", d, 0);
    rd(A_ISTAT, d); check("R6 sticky level", d & 32'h1, 1);
    wr(A_ISTAT, 32'h1);
    idle(1);
    rd(A_ISTAT, d); check("R6 stays clear", d & 32'h1, 0);
    check("R9 irq low", 32'(irq), 0);
  endtask

  task automatic t_overflow();
    logic [31:0] d;
    logic [7:0] b;
    int bad;
    wr(A_IEN, 32'h100);
    for (int i = 0; i < DEPTH; i++) push_rx(8'(i));
    rd(A_ISTAT, d); check("R7 no overflow yet", d & 32'h100, 0);
    push_rx(8'hEE);
    rd(A_FSTAT, d); check("R7 count unchanged", d, 32'(DEPTH));
    rd(A_ISTAT, d); check("R7 overflow flag", d & 32'h100, 32'h100);
    check("R9 irq ovf", 32'(irq), 1);
    bad = 0;
    for (int i = 0; i < DEPTH; i++) begin
      rd_pop(b);
      if (b !== 8'(i)) bad++;
    end
    check("R7 R11 contents kept", 32'(bad), 0);
    push_rx(8'h11); push_rx(8'h22);
    wr(A_FCTRL, 32'h0000_8000);
    rd(A_FSTAT, d); check("R2 rx flush", d, 0);
    rd(A_FCTRL, d); check("R2 flush reads 0", d, 0);
  endtask

  task automatic t_tx();
    logic [31:0] d;
    wr(A_FCTRL, 32'h0102_0000);
    for (int i = 1; i <= 5; i++) wr(A_TXD, 32'(8'h50 + 8'(i)));
    rd(A_FSTAT, d); check("R3 tx count", d, 32'h0005_0000);
    check("R10 tx dma low", 32'(dma_tx_req), 0);
    wr(A_ISTAT, 32'hFFFF_FFFF);
    idle(1);
    rd(A_ISTAT, d); check("R5 above trigger", d & 32'h10, 0);
    for (int i = 1; i <= 3; i++) begin
      check("R11 tx order", 32'(eng_tx_byte), 32'(8'h50 + 8'(i)));
      eng_tx_pop = 1'b1; @(negedge clk); eng_tx_pop = 1'b0;
    end
    check("R10 tx dma at trigger", 32'(dma_tx_req), 1);
    idle(1);
    rd(A_ISTAT, d); check("R5 at trigger", d & 32'h10, 32'h10);
    for (int i = 4; i <= 5; i++) begin
      check("R11 tx order", 32'(eng_tx_byte), 32'(8'h50 + 8'(i)));
      eng_tx_pop = 1'b1; @(negedge clk); eng_tx_pop = 1'b0;
    end
    check("R11 tx empty", 32'(eng_tx_empty), 1);
    wr(A_TXD, 32'h77); wr(A_TXD, 32'h78);
    wr(A_FCTRL, 32'h8000_0000);
    rd(A_FSTAT, d); check("R2 tx flush", d, 0);
    rd(A_FCTRL, d); check("R2 tx flush reads 0", d, 0);
  endtask

  task automatic t_done();
    logic [31:0] d;
    wr(A_IEN, 32'h1000);
    wr(A_ISTAT, 32'hFFFF_FFFF);
    eng_done = 1'b1; @(negedge clk); eng_done = 1'b0;
    rd(A_ISTAT, d); check("R8 done set", d & 32'h1000, 32'h1000);
    check("R9 irq done", 32'(irq), 1);
    reg_we = 1'b1; reg_addr = A_ISTAT; reg_wdata = 32'h1000; eng_done = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; eng_done = 1'b0;
    rd(A_ISTAT, d); check("R8 collision keeps flag", d & 32'h1000, 32'h1000);
    wr(A_ISTAT, 32'h1000);
    rd(A_ISTAT, d); check("R8 clear alone", d & 32'h1000, 0);
    check("R9 irq cleared", 32'(irq), 0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(A_IEN, 32'h0);
    idle(1);
    rd(A_ISTAT, d); check("R5 txreq pending", d & 32'h10, 32'h10);
    check("R9 disabled flag", 32'(irq), 0);
    wr(A_IEN, 32'h10);
    check("R9 enabled flag", 32'(irq), 1);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_w1c();
    t_rx_thresh();
    t_rx_order();
    t_overflow();
    t_tx();
    t_done();
    t_mask();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule